// File: doc/BRIEF.md
# Memory-Mapped Slave with Cycles-Remaining Countdown

This block is a register-array slave for a pipelined master. It does not stall the master with a wait or acknowledge line. The master presents a read or write request for one clock cycle and can then move on, because the slave captures the whole request and keeps it internally until the access is done. The access runs against sixteen 32-bit words and takes a fixed number of cycles, set by a parameter. While an access is in flight, a 2-bit count output tells the master how many cycles are left. With that warning the master can restart its own pipeline a cycle or two before read data appears.

Read data is presented for exactly one cycle, together with a valid strobe, and the master must take it in that cycle. A write signals completion only through the count reaching zero. A second request may arrive while the first is still counting down. That request is parked in a one-entry holding slot, and a busy flag tells the master to withhold any further request until the slot drains.

Top module: `countdown_slave`

## Requirements
- R1: While reset is high and in the first cycle after it, `cnt` is 0, `rvalid` is 0 and `busy` is 0.
- R2: A read is accepted in a cycle where `req_rd` is 1 and `busy` is 0. It completes exactly LATENCY cycles after the cycle in which it was presented. In that completion cycle `rvalid` is 1 for that single cycle and `rdata` carries the addressed word. Outside completion cycles `rvalid` is 0 and `rdata` is 0.
- R3: In each cycle from the one after acceptance to the completion cycle, `cnt` equals the number of cycles left until completion, clipped at 3. With LATENCY 5 the sequence is 3,3,2,1,0. `cnt` is 0 in the completion cycle and while no access is in flight.
- R4: Address, write data and strobes are needed only in the cycle the request is presented. Changing them afterwards does not alter the access.
- R5: A write is accepted and counted down the same way as a read, with `rvalid` staying 0. The word is updated at the end of its completion cycle, and a later read of that address returns the written value.
- R6: A request accepted while another access is in flight is held pending, and `busy` is 1 from the next cycle until the in-flight access completes. The held access then starts its own full countdown and completes LATENCY cycles after the earlier access's completion cycle.
- R7: A request presented while `busy` is 1 is ignored: it causes no completion and writes no word.
- R8: A request with `req_rd` and `req_wr` both 1 is performed as a read only, and the word is left unchanged.
- R9: After reset every word of the array reads as 0.
- R10: With LATENCY 1, an accepted read returns its data with `rvalid` 1 in the very next cycle. `cnt` stays 0 in that configuration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_rd | input | 1 | Read request strobe, one cycle |
| req_wr | input | 1 | Write request strobe, one cycle |
| req_addr | input | 4 | Word address of the request |
| req_wdata | input | 32 | Write data of the request |
| busy | output | 1 | Holding slot occupied; new requests are ignored |
| cnt | output | 2 | Cycles remaining until completion, clipped at 3 |
| rvalid | output | 1 | Read data valid, one cycle |
| rdata | output | 32 | Read data, 0 when not valid |

## Verification
The hardest situation to reach is three requests in overlapping windows: one in flight, one waiting in the holding slot, and a third arriving while `busy` is high. The stimulus issues a read and then a second read on the very next cycle, which lands in the holding slot. Two cycles later, while `busy` is high, it issues a write. It then checks the full countdown of the held read after the first read completes. It also confirms that no third completion follows, and that a read-back shows the word the blocked write aimed at is unchanged. A second instance built with the minimum latency covers next-cycle delivery and a request issued in a completion cycle.

// File: rtl/cds_pkg.sv
package cds_pkg;

    localparam int DATA_W  = 32;
    localparam int WORDS   = 16;
    localparam int ADDR_W  = $clog2(WORDS);
    localparam int CNT_W   = 2;
    localparam int CNT_MAX = (1 << CNT_W) - 1;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    typedef struct packed {
        op_e               op;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } req_t;

    function automatic logic [CNT_W-1:0] clip_count(input logic [7:0] left);
        if (left > 8'(CNT_MAX)) begin
            return CNT_W'(CNT_MAX);
        end
        return left[CNT_W-1:0];
    endfunction

    function automatic op_e decode_op(input logic rd, input logic wr);
        if (rd) begin
            return OP_READ;
        end
        if (wr) begin
            return OP_WRITE;
        end
        return OP_NONE;
    endfunction

endpackage

// File: rtl/cds_hold.sv
module cds_hold
    import cds_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  req_t incoming,
    input  logic done,
    output req_t act,
    output logic act_v,
    output logic pend_v,
    output logic start
);

    req_t pend;
    logic in_v;
    logic free;

    assign in_v  = (incoming.op != OP_NONE) && !pend_v;
    assign free  = !act_v || done;
    assign start = free && (pend_v || in_v);

    always_ff @(posedge clk) begin
        if (rst) begin
            act    <= '0;
            act_v  <= 1'b0;
            pend   <= '0;
            pend_v <= 1'b0;
        end else if (free) begin
            if (pend_v) begin
                act    <= pend;
                act_v  <= 1'b1;
                pend_v <= 1'b0;
            end else if (in_v) begin
                act   <= incoming;
                act_v <= 1'b1;
            end else begin
                act_v <= 1'b0;
            end
        end else if (in_v) begin
            pend   <= incoming;
            pend_v <= 1'b1;
        end
    end

endmodule

// File: rtl/cds_timer.sv
module cds_timer
    import cds_pkg::*;
#(
    parameter int LATENCY = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             act_v,
    output logic             done,
    output logic [CNT_W-1:0] cnt
);

    generate
        if (LATENCY == 1) begin : g_single
            assign done = act_v;
            assign cnt  = '0;
        end else begin : g_count
            localparam int REM_W = $clog2(LATENCY);
            logic [REM_W-1:0] rem;

            always_ff @(posedge clk) begin
                if (rst) begin
                    rem <= '0;
                end else if (start) begin
                    rem <= REM_W'(LATENCY - 1);
                end else if (rem != '0) begin
                    rem <= rem - 1'b1;
                end
            end

            assign done = act_v && (rem == '0);
            assign cnt  = act_v ? clip_count(8'(rem)) : '0;
        end
    endgenerate

endmodule

// File: rtl/cds_regfile.sv
module cds_regfile
    import cds_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rword
);

    logic [DATA_W-1:0] words [WORDS];

    always_ff @(posedge clk) begin
        for (int i = 0; i < WORDS; i++) begin
            if (rst) begin
                words[i] <= '0;
            end else if (we && (waddr == ADDR_W'(i))) begin
                words[i] <= wdata;
            end
        end
    end

    assign rword = words[raddr];

endmodule

// File: rtl/countdown_slave.sv
module countdown_slave
    import cds_pkg::*;
#(
    parameter int LATENCY = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_rd,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic [CNT_W-1:0]  cnt,
    output logic              rvalid,
    output logic [DATA_W-1:0] rdata
);

    req_t              incoming;
    req_t              act;
    logic              act_v;
    logic              pend_v;
    logic              start;
    logic              done;
    logic              wr_en;
    logic [DATA_W-1:0] rword;

    assign incoming.op   = decode_op(req_rd, req_wr);
    assign incoming.addr = req_addr;
    assign incoming.data = req_wdata;

    cds_hold u_hold (
        .clk      (clk),
        .rst      (rst),
        .incoming (incoming),
        .done     (done),
        .act      (act),
        .act_v    (act_v),
        .pend_v   (pend_v),
        .start    (start)
    );

    cds_timer #(.LATENCY(LATENCY)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .act_v (act_v),
        .done  (done),
        .cnt   (cnt)
    );

    assign wr_en = done && (act.op == OP_WRITE);

    cds_regfile u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_en),
        .waddr (act.addr),
        .wdata (act.data),
        .raddr (act.addr),
        .rword (rword)
    );

    assign busy   = pend_v;
    assign rvalid = done && (act.op == OP_READ);
    assign rdata  = rvalid ? rword : '0;

endmodule

// File: rtl/cds_checker.sv
module cds_checker
    import cds_pkg::*;
#(
    parameter int LATENCY = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             req_rd,
    input logic             busy,
    input logic [CNT_W-1:0] cnt,
    input logic             rvalid
);

    logic rst_d;

    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst_d) begin
            // R1
            a_reset_quiet_r1: assert (cnt == '0 && !rvalid && !busy);
        end
    end

    p_cnt_two_to_one_r3: assert property (@(posedge clk) disable iff (rst)
        (cnt == 2'd2) |=> (cnt == 2'd1));

    p_cnt_one_to_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (cnt == 2'd1) |=> (cnt == 2'd0));

    p_valid_at_zero_r2: assert property (@(posedge clk) disable iff (rst)
        rvalid |-> (cnt == 2'd0));

    p_busy_holds_r6: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt != 2'd0) |=> busy);

    p_min_latency_r10: assert property (@(posedge clk) disable iff (rst)
        (LATENCY == 1 && req_rd && !busy) |=> rvalid);

endmodule

bind countdown_slave cds_checker #(.LATENCY(LATENCY)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .req_rd (req_rd),
    .busy   (busy),
    .cnt    (cnt),
    .rvalid (rvalid)
);

// File: tb/tb_countdown_slave.sv
module tb_countdown_slave;

    localparam int LAT = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_rd = 1'b0, req_wr = 1'b0;
    logic [3:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        busy, rvalid;
    logic [1:0]  cnt;
    logic [31:0] rdata;

    logic        m_rd = 1'b0, m_wr = 1'b0;
    logic [3:0]  m_addr = '0;
    logic [31:0] m_wdata = '0;
    logic        m_busy, m_rvalid;
    logic [1:0]  m_cnt;
    logic [31:0] m_rdata;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    countdown_slave #(.LATENCY(LAT)) dut (
        .clk(clk), .rst(rst), .req_rd(req_rd), .req_wr(req_wr),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .busy(busy), .cnt(cnt), .rvalid(rvalid), .rdata(rdata)
    );

    countdown_slave #(.LATENCY(1)) dut_min (
        .clk(clk), .rst(rst), .req_rd(m_rd), .req_wr(m_wr),
        .req_addr(m_addr), .req_wdata(m_wdata),
        .busy(m_busy), .cnt(m_cnt), .rvalid(m_rvalid), .rdata(m_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] clip(input int left);
        return (left > 3) ? 2'd3 : 2'(left);
    endfunction

    task automatic clear_req();
        req_rd = 1'b0; req_wr = 1'b0;
    endtask

    // Starts at a negedge with the design idle; ends one cycle after completion.
    task automatic t_access(input logic rd, input logic wr, input logic [3:0] a,
                            input logic [31:0] wd, input logic [31:0] exp_rd);
        req_rd = rd; req_wr = wr; req_addr = a; req_wdata = wd;
        for (int k = 1; k <= LAT; k++) begin
            @(negedge clk);
            if (k == 1) begin
                clear_req();
                req_addr = ~a;               // R4: request no longer held by master
                req_wdata = 32'hBAD0_BAD0;
            end
            chk("R3 countdown", {30'd0, cnt}, {30'd0, clip(LAT - k)});
            chk(rd ? "R2 rvalid" : "R5 no rvalid on write", {31'd0, rvalid},
                {31'd0, rd && k == LAT});
            if (rd && k == LAT) chk("R2 R4 read data", rdata, exp_rd);
        end
        @(negedge clk);
        chk("R3 idle count", {30'd0, cnt}, 32'd0);
    endtask

    task automatic t_reset();
        chk("R1 cnt", {30'd0, cnt}, 32'd0);
        chk("R1 rvalid", {31'd0, rvalid}, 32'd0);
        chk("R1 busy", {31'd0, busy}, 32'd0);
        t_access(1'b1, 1'b0, 4'd3, '0, 32'd0);   // R9
    endtask

    task automatic t_write_read();
        t_access(1'b0, 1'b1, 4'd2, 32'hCAFE_0002, '0);
        t_access(1'b1, 1'b0, 4'd2, '0, 32'hCAFE_0002);  // R5
        t_access(1'b0, 1'b1, 4'd7, 32'h1111_0007, '0);
        t_access(1'b0, 1'b1, 4'd1, 32'hAAAA_0001, '0);
    endtask

    task automatic t_both_strobes();
        t_access(1'b1, 1'b1, 4'd2, 32'hDEAD_BEEF, 32'hCAFE_0002); // R8
        t_access(1'b1, 1'b0, 4'd2, '0, 32'hCAFE_0002);            // R8 unchanged
    endtask

    task automatic t_pending();
        req_rd = 1'b1; req_addr = 4'd1;                 // A, cycle c
        @(negedge clk);                                 // c+1
        chk("R6 busy before hold", {31'd0, busy}, 32'd0);
        chk("R3 count c+1", {30'd0, cnt}, 32'd3);
        req_rd = 1'b1; req_addr = 4'd2;                 // B goes to hold slot
        @(negedge clk);                                 // c+2
        clear_req();
        chk("R6 busy held", {31'd0, busy}, 32'd1);
        @(negedge clk);                                 // c+3
        chk("R6 busy c+3", {31'd0, busy}, 32'd1);
        chk("R3 count c+3", {30'd0, cnt}, 32'd2);
        req_wr = 1'b1; req_addr = 4'd7; req_wdata = 32'hDEAD_0007; // R7 blocked
        @(negedge clk);                                 // c+4
        clear_req();
        chk("R3 count c+4", {30'd0, cnt}, 32'd1);
        @(negedge clk);                                 // c+5: A completes
        chk("R6 A valid", {31'd0, rvalid}, 32'd1);
        chk("R6 A data", rdata, 32'hAAAA_0001);
        chk("R6 busy at A done", {31'd0, busy}, 32'd1);
        for (int k = 1; k <= LAT; k++) begin
            @(negedge clk);                             // c+5+k
            chk("R6 B count", {30'd0, cnt}, {30'd0, clip(LAT - k)});
            chk("R6 busy cleared", {31'd0, busy}, 32'd0);
            chk("R6 B valid", {31'd0, rvalid}, {31'd0, k == LAT});
            if (k == LAT) chk("R6 B data", rdata, 32'hCAFE_0002);
        end
        @(negedge clk);
        chk("R7 no third completion", {31'd0, rvalid}, 32'd0);
        chk("R7 idle count", {30'd0, cnt}, 32'd0);
        t_access(1'b1, 1'b0, 4'd7, '0, 32'h1111_0007);  // R7 word unchanged
    endtask

    task automatic t_min_latency();
        m_wr = 1'b1; m_addr = 4'd4; m_wdata = 32'h0000_4444;
        @(negedge clk);
        m_wr = 1'b0;
        chk("R10 write no valid", {31'd0, m_rvalid}, 32'd0);
        chk("R10 count zero", {30'd0, m_cnt}, 32'd0);
        m_rd = 1'b1; m_addr = 4'd4;                     // issued in completion cycle
        @(negedge clk);
        chk("R10 next-cycle valid", {31'd0, m_rvalid}, 32'd1);
        chk("R10 next-cycle data", m_rdata, 32'h0000_4444);
        m_addr = 4'd0;                                  // back-to-back read
        @(negedge clk);
        m_rd = 1'b0;
        chk("R10 back-to-back valid", {31'd0, m_rvalid}, 32'd1);
        chk("R10 back-to-back data", m_rdata, 32'd0);
        @(negedge clk);
        chk("R10 quiet", {31'd0, m_rvalid}, 32'd0);
        chk("R10 busy", {31'd0, m_busy}, 32'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 cnt during reset", {30'd0, cnt}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_write_read();
        t_both_strobes();
        t_pending();
        t_min_latency();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        #(20 * 200000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule